// File: doc/BRIEF.md
# Serial Flash Sector-Erase Command Front-End

This block is the device-side command logic of a small serial flash. It receives SPI mode 0 frames on chip-select, serial clock and serial data in. It decodes three commands: write-enable, read-status and sector-erase. The block holds the write-enable latch and the busy flag. A down-counter in system clocks times each erase.

An erase is started only when all three of these hold:
- a write-enable frame set the latch earlier;
- chip-select rises exactly after the 32nd serial bit of the erase frame;
- the addressed sector is outside the region fenced off by the protect code.

When the erase starts, the block sends a one-clock erase request to the array controller, carrying the sector index. It clears the latch and holds the busy flag for the programmed number of clocks.

The serial pins are asynchronous to the system clock and are synchronized inside the block. The protect code arrives as a plain input held by the surrounding chip.

Top module: `flash_erase_fe`

## Requirements
- R1: After reset, wip_o, wel_o, erase_req_o and sdo_o are all 0.
- R2: A frame of exactly 8 bits carrying opcode 0x06, sent while idle, sets wel_o to 1.
- R3: A frame of exactly 32 bits (opcode 0x20, then a 24-bit address, MSB first) issues exactly one single-cycle erase_req_o pulse when the latch is set, the block is idle and the sector is not protected. erase_sect_o carries address bits 15:12 with that pulse, and address bits 11:0 have no effect.
- R4: An erase frame sent while wel_o is 0 produces no request, and wip_o stays 0.
- R5: An erase frame whose chip-select rise follows any bit count other than 32 (for example 31 or 40) is not executed, and wel_o keeps its value.
- R6: On an accepted erase, wip_o rises in the same cycle as erase_req_o and stays 1 for exactly ERASE_CYC clocks. wel_o is 0 from that cycle on.
- R7: bp_i protects sectors as follows, and an erase aimed at a protected sector is not executed while wel_o stays 1:
  - value 0 protects nothing;
  - values 1, 2, 3 and 4 protect the top 1, 2, 4 and 8 sectors of 16;
  - values 5 to 7 protect all sectors.
- R8: While wip_o is 1, write-enable and erase frames have no effect.
- R9: After the 8 bits of opcode 0x05, the status byte is shifted out on sdo_o, MSB first, with each bit driven after a falling serial clock edge. Its bits are:
  - bit 0 is wip;
  - bit 1 is wel;
  - bits 4:2 are bp_i;
  - bits 7:5 are 0.
  The byte repeats, with fresh contents, for as long as chip-select stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock, asynchronous |
| csn_i | input | 1 | Chip-select, active low, asynchronous |
| sdi_i | input | 1 | Serial data in, sampled on rising sck_i |
| bp_i | input | 3 | Block-protect code |
| sdo_o | output | 1 | Serial data out (status byte) |
| wip_o | output | 1 | Erase in progress |
| wel_o | output | 1 | Write-enable latch |
| erase_req_o | output | 1 | One-cycle erase request |
| erase_sect_o | output | SECT_W | Sector index for the request |

## Verification
The assertions rest on three assumptions about the inputs:
- bp_i is stable in the cycle before a request is decided;
- each serial-clock phase lasts well beyond the synchronizer latency;
- sdi_i and csn_i change only while sck_i is low.

The bench drives every serial edge through eight system clocks per phase. It changes bp_i only between frames, while the block is idle, and it moves chip-select only with the serial clock low. This keeps each decoded bit count and each protect decision unambiguous.

// File: rtl/flash_fe_pkg.sv
package flash_fe_pkg;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_SE   = 8'h20;
  localparam int CNT_W   = 6;
  localparam int FRAME_W = 32;

  // top 1/16,1/8,1/4,1/2 for codes 1..4, everything from 5 up
  function automatic logic sect_locked(input logic [2:0] bp, input int unsigned sect,
                                       input int unsigned n_sect);
    int unsigned span;
    if (bp == 3'd0) return 1'b0;
    if (bp >= 3'd5) return 1'b1;
    span = n_sect >> (5 - int'(bp));
    return sect >= (n_sect - span);
  endfunction

  function automatic logic [7:0] status_byte(input logic [2:0] bp, input logic wel,
                                             input logic wip);
    return {3'b000, bp, wel, wip};
  endfunction
endpackage

// File: rtl/flash_spi_sync.sv
module flash_spi_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic csn_i,
  input  logic sdi_i,
  output logic sck_rise_o,
  output logic sck_fall_o,
  output logic cs_act_o,
  output logic cs_end_o,
  output logic sdi_o
);
  logic [STAGES-1:0] sck_q, csn_q, sdi_q;
  logic sck_d, csn_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q <= '0;
      csn_q <= '1;
      sdi_q <= '0;
      sck_d <= 1'b0;
      csn_d <= 1'b1;
    end else begin
      sck_q <= {sck_q[STAGES-2:0], sck_i};
      csn_q <= {csn_q[STAGES-2:0], csn_i};
      sdi_q <= {sdi_q[STAGES-2:0], sdi_i};
      sck_d <= sck_q[STAGES-1];
      csn_d <= csn_q[STAGES-1];
    end
  end

  assign sck_rise_o = sck_q[STAGES-1] & ~sck_d;
  assign sck_fall_o = ~sck_q[STAGES-1] & sck_d;
  assign cs_act_o   = ~csn_q[STAGES-1];
  assign cs_end_o   = csn_q[STAGES-1] & ~csn_d;
  assign sdi_o      = sdi_q[STAGES-1];
endmodule

// File: rtl/flash_frame_rx.sv
module flash_frame_rx
  import flash_fe_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sck_rise_i,
  input  logic               cs_act_i,
  input  logic               sdi_i,
  output logic [CNT_W-1:0]   bit_cnt_o,
  output logic [FRAME_W-1:0] frame_o,
  output logic               rdsr_start_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt_o <= '0;
      frame_o   <= '0;
    end else if (!cs_act_i) begin
      bit_cnt_o <= '0;
    end else if (sck_rise_i) begin
      frame_o <= {frame_o[FRAME_W-2:0], sdi_i};
      if (bit_cnt_o != CNT_MAX) bit_cnt_o <= bit_cnt_o + 1'b1;
    end
  end

  // eighth rising edge completes a status-read opcode
  assign rdsr_start_o = cs_act_i && sck_rise_i && (bit_cnt_o == CNT_W'(7)) &&
                        ({frame_o[6:0], sdi_i} == OP_RDSR);
endmodule

// File: rtl/flash_erase_ctrl.sv
module flash_erase_ctrl
  import flash_fe_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int SECT_W    = 4,
  parameter int ERASE_CYC = 4000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cs_end_i,
  input  logic [CNT_W-1:0]   bit_cnt_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [2:0]         bp_i,
  output logic               wel_o,
  output logic               wip_o,
  output logic               req_o,
  output logic [SECT_W-1:0]  sect_o
);
  localparam int TMR_W = $clog2(ERASE_CYC);
  localparam int unsigned N_SECT = 1 << SECT_W;

  logic [TMR_W-1:0]  tmr_q;
  logic [SECT_W-1:0] sect_w;
  logic              wren_hit, se_hit, locked;

  assign sect_w   = frame_i[ADDR_W-1 -: SECT_W];
  assign wren_hit = cs_end_i && (bit_cnt_i == CNT_W'(8))  && (frame_i[7:0] == OP_WREN);
  assign se_hit   = cs_end_i && (bit_cnt_i == CNT_W'(32)) && (frame_i[31:24] == OP_SE);
  assign locked   = sect_locked(bp_i, int'(unsigned'(sect_w)), N_SECT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wel_o  <= 1'b0;
      wip_o  <= 1'b0;
      req_o  <= 1'b0;
      sect_o <= '0;
      tmr_q  <= '0;
    end else begin
      req_o <= 1'b0;
      if (wip_o) begin
        if (tmr_q == '0) wip_o <= 1'b0;
        else             tmr_q <= tmr_q - 1'b1;
      end else if (se_hit && wel_o && !locked) begin
        wip_o  <= 1'b1;
        wel_o  <= 1'b0;
        req_o  <= 1'b1;
        sect_o <= sect_w;
        tmr_q  <= TMR_W'(ERASE_CYC - 1);
      end else if (wren_hit) begin
        wel_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/flash_status_tx.sv
module flash_status_tx (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sck_fall_i,
  input  logic       cs_act_i,
  input  logic       load_i,
  input  logic [7:0] status_i,
  output logic       sdo_o
);
  logic [7:0] sh_q;
  logic [2:0] cnt_q;
  logic       act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
      act_q <= 1'b0;
      sdo_o <= 1'b0;
    end else if (!cs_act_i) begin
      act_q <= 1'b0;
      cnt_q <= '0;
      sdo_o <= 1'b0;
    end else if (load_i) begin
      act_q <= 1'b1;
      sh_q  <= status_i;
      cnt_q <= '0;
    end else if (act_q && sck_fall_i) begin
      sdo_o <= sh_q[7];
      cnt_q <= cnt_q + 1'b1;
      // refresh after the last bit so a held frame sees live status
      if (cnt_q == 3'd7) sh_q <= status_i;
      else               sh_q <= {sh_q[6:0], 1'b0};
    end
  end
endmodule

// File: rtl/flash_erase_fe.sv
module flash_erase_fe
  import flash_fe_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int SECT_W      = 4,
  parameter int ERASE_CYC   = 4000,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_i,
  input  logic              csn_i,
  input  logic              sdi_i,
  input  logic [2:0]        bp_i,
  output logic              sdo_o,
  output logic              wip_o,
  output logic              wel_o,
  output logic              erase_req_o,
  output logic [SECT_W-1:0] erase_sect_o
);
  logic sck_rise, sck_fall, cs_act, cs_end, sdi_s, rdsr_start;
  logic [CNT_W-1:0]   bit_cnt;
  logic [FRAME_W-1:0] frame;

  flash_spi_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .sck_i, .csn_i, .sdi_i,
    .sck_rise_o(sck_rise), .sck_fall_o(sck_fall),
    .cs_act_o(cs_act), .cs_end_o(cs_end), .sdi_o(sdi_s)
  );

  flash_frame_rx u_rx (
    .clk_i, .rst_ni,
    .sck_rise_i(sck_rise), .cs_act_i(cs_act), .sdi_i(sdi_s),
    .bit_cnt_o(bit_cnt), .frame_o(frame), .rdsr_start_o(rdsr_start)
  );

  flash_erase_ctrl #(.ADDR_W(ADDR_W), .SECT_W(SECT_W), .ERASE_CYC(ERASE_CYC)) u_ctrl (
    .clk_i, .rst_ni,
    .cs_end_i(cs_end), .bit_cnt_i(bit_cnt), .frame_i(frame), .bp_i,
    .wel_o, .wip_o, .req_o(erase_req_o), .sect_o(erase_sect_o)
  );

  flash_status_tx u_tx (
    .clk_i, .rst_ni,
    .sck_fall_i(sck_fall), .cs_act_i(cs_act), .load_i(rdsr_start),
    .status_i(status_byte(bp_i, wel_o, wip_o)), .sdo_o
  );
endmodule

// File: rtl/flash_erase_fe_chk.sv
module flash_erase_fe_chk
  import flash_fe_pkg::*;
#(
  parameter int SECT_W    = 4,
  parameter int ERASE_CYC = 4000
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [2:0]        bp_i,
  input logic              wip_o,
  input logic              wel_o,
  input logic              erase_req_o,
  input logic [SECT_W-1:0] erase_sect_o
);
  localparam int unsigned N_SECT = 1 << SECT_W;
  logic [31:0] run_q;
  logic [2:0]  bp_q;
  logic        locked_c;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= '0;
      bp_q  <= '0;
    end else begin
      bp_q  <= bp_i;
      run_q <= wip_o ? run_q + 1 : '0;
    end
  end

  assign locked_c = sect_locked(bp_q, int'(unsigned'(erase_sect_o)), N_SECT);

  p_req_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_req_o |=> !erase_req_o);
  p_req_needs_wel_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_req_o |-> $past(wel_o));
  p_req_starts_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_req_o |-> wip_o && !$past(wip_o));
  p_wel_low_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wip_o |-> !wel_o);
  p_busy_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wip_o |-> run_q < 32'(ERASE_CYC));
  p_busy_len_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wip_o) |-> run_q == 32'(ERASE_CYC));
  p_no_locked_req_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_req_o |-> !locked_c);
endmodule

bind flash_erase_fe flash_erase_fe_chk #(.SECT_W(SECT_W), .ERASE_CYC(ERASE_CYC)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .bp_i(bp_i), .wip_o(wip_o), .wel_o(wel_o),
  .erase_req_o(erase_req_o), .erase_sect_o(erase_sect_o)
);

// File: tb/flash_erase_fe_tb_top.sv
module flash_erase_fe_tb_top;
  localparam int ERASE_CYC = 1200;
  localparam int HALF      = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, csn = 1'b1, sdi = 1'b0;
  logic [2:0] bp = 3'd0;
  logic sdo_o, wip_o, wel_o, erase_req_o;
  logic [3:0] erase_sect_o;

  int n_chk = 0, n_err = 0, run = 0;
  bit done = 0;
  logic [3:0] exp_q[$];
  logic [3:0] e;
  logic [15:0] st;

  always #2 clk = ~clk;

  flash_erase_fe #(.ERASE_CYC(ERASE_CYC)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .csn_i(csn), .sdi_i(sdi), .bp_i(bp),
    .sdo_o, .wip_o, .wel_o, .erase_req_o, .erase_sect_o
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send_bits(input logic [39:0] d, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdi = d[i];
      repeat (HALF) @(negedge clk);
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic frame(input logic [39:0] d, input int n);
    csn = 1'b0;
    repeat (HALF) @(negedge clk);
    send_bits(d, n);
    repeat (HALF) @(negedge clk);
    csn = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic read_status(output logic [15:0] got);
    got = '0;
    csn = 1'b0;
    repeat (HALF) @(negedge clk);
    send_bits(40'h05, 8);
    for (int i = 0; i < 16; i++) begin
      repeat (HALF) @(negedge clk);
      got = {got[14:0], sdo_o};
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    csn = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic wait_idle();
    while (wip_o) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (erase_req_o) begin
        if (exp_q.size() == 0) chk(1'b0, "R3 unexpected request", int'(erase_sect_o), 0);
        else begin
          e = exp_q.pop_front();
          chk(erase_sect_o == e, "R3 sector", int'(erase_sect_o), int'(e));
          chk(!wel_o, "R6 latch cleared at start", int'(wel_o), 0);
        end
      end
      if (wip_o) run++;
      else if (run != 0) begin
        chk(run == ERASE_CYC, "R6 busy length", run, ERASE_CYC);
        run = 0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk({wip_o, wel_o, erase_req_o, sdo_o} == 4'b0, "R1 reset outputs",
        int'({wip_o, wel_o, erase_req_o, sdo_o}), 0);

    read_status(st);
    chk(st == 16'h0000, "R9 idle status", int'(st), 'h0000);

    frame({8'h0, 8'h20, 24'h003ABC}, 32);
    repeat (50) @(negedge clk);
    chk(!wip_o, "R4 erase without latch", int'(wip_o), 0);

    frame(40'h06, 8);
    chk(wel_o, "R2 latch set", int'(wel_o), 1);
    read_status(st);
    chk(st == 16'h0202, "R9 latch status", int'(st), 'h0202);

    frame({9'h0, 8'h20, 23'h005FFF}, 31);
    chk(!wip_o && wel_o, "R5 short frame", int'({wip_o, wel_o}), 1);
    frame({8'h20, 24'h005FFF, 8'h00}, 40);
    chk(!wip_o && wel_o, "R5 long frame", int'({wip_o, wel_o}), 1);

    exp_q.push_back(4'h5);
    frame({8'h0, 8'h20, 24'h005FFF}, 32);
    chk(wip_o && !wel_o, "R6 busy start", int'({wip_o, wel_o}), 2);
    read_status(st);
    chk(st == 16'h0101, "R9 busy status", int'(st), 'h0101);
    frame(40'h06, 8);
    chk(!wel_o, "R8 write-enable while busy", int'(wel_o), 0);
    frame({8'h0, 8'h20, 24'h002000}, 32);
    wait_idle();
    chk(!wel_o, "R8 latch still clear", int'(wel_o), 0);

    frame(40'h06, 8);
    exp_q.push_back(4'hA);
    frame({8'h0, 8'h20, 24'h00A123}, 32);
    wait_idle();

    bp = 3'd1;
    frame(40'h06, 8);
    frame({8'h0, 8'h20, 24'h00F000}, 32);
    repeat (20) @(negedge clk);
    chk(!wip_o && wel_o, "R7 top sector locked", int'({wip_o, wel_o}), 1);
    exp_q.push_back(4'hE);
    frame({8'h0, 8'h20, 24'h00E000}, 32);
    wait_idle();

    bp = 3'd3;
    frame(40'h06, 8);
    frame({8'h0, 8'h20, 24'h00C000}, 32);
    repeat (20) @(negedge clk);
    chk(!wip_o && wel_o, "R7 quarter locked", int'({wip_o, wel_o}), 1);
    exp_q.push_back(4'hB);
    frame({8'h0, 8'h20, 24'h00B000}, 32);
    wait_idle();

    bp = 3'd5;
    frame(40'h06, 8);
    frame({8'h0, 8'h20, 24'h000000}, 32);
    repeat (20) @(negedge clk);
    chk(!wip_o && wel_o, "R7 all locked", int'({wip_o, wel_o}), 1);
    read_status(st);
    chk(st == 16'h1616, "R9 protect field", int'(st), 'h1616);

    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R3 missing requests", exp_q.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule